// File: doc/BRIEF.md
# Clock Configuration Lock Register Unit

This block holds the byte-wide configuration registers of a small controller's clock-control area: a peripheral clock select register, a processor mode register, and shadow copies of the protected clock-control bits (main clock stop, stop-clocks-in-wait, the two CPU clock source bits, stop-mode request, oscillation-stop detect enable, and the PLL control byte). Software reaches them through a simple synchronous port with an address, a write strobe, write data and combinational read data. Two write-enable bits come from a separate protect register outside this block.

Two set-only lock bits in the mode register freeze parts of the configuration until reset. The clock lock freezes the clock sources, the stop controls and the PLL byte, and it keeps the bus clock running through a wait instruction. The watchdog lock turns on the ring oscillator, makes it the watchdog count source, keeps the watchdog running in wait and hold, and blocks the stop-mode request. The SFR wait-count bit can only change while the PLL is disabled. A sticky flag reports a 1-wait setting combined with an enabled high-frequency PLL.

Address map: 0 peripheral clock select, 1 mode, 2 clock control A (bit0 main stop, bit1 stop clocks in wait, bit2 CPU source bit 0), 3 clock control B (bit0 stop request, bit1 CPU source bit 1, bit2 oscillation-stop detect enable), 4 PLL control (bit7 PLL enable), 5 status (bit0 error flag).

Top module: `clk_cfg_lock`

## Requirements
- R1: After reset the peripheral clock select reads 0x03, and the mode, clock control A, clock control B, PLL control and status registers read 0x00.
- R2: A write to address 0 takes effect only while prot_i[0] is 1; bit0 drives tmr_clk_f1_o, bit1 drives sio_clk_f1_o, and bits 7:2 always read 0.
- R3: A write to address 1 takes effect only while prot_i[1] is 1; mode bits 7:3 are discarded and read 0.
- R4: Mode bit0 (sfr_wait1_o, 1 means one wait) accepts a new value only while PLL control bit7 is 0.
- R5: Mode bit1 (clk_lock_o) can be set by a write but a write of 0 never clears it; only reset clears it.
- R6: While clk_lock_o is 1, writes to clock control A, to bits 0 to 2 of clock control B and to every PLL control bit have no effect, and bclk_keep_o is 1.
- R7: Mode bit2 is set-only like R5; while it is 1, ring_osc_en_o, wdt_src_ring_o and wdt_keep_run_o are 1.
- R8: While mode bit2 is 1, writes to clock control B bit0 (stop_req_o) have no effect, while its other bits stay writable when the clock lock is 0.
- R9: Lock gating uses register values from before the write's clock edge, so one write that sets a lock and changes other bits of the same register is fully accepted.
- R10: pll_err_o becomes 1 after any edge where sfr_wait1_o, PLL control bit7 and pll_hi_freq_i are all 1, stays 1 otherwise, and a write of bit0=1 to address 5 clears it unless the set condition holds in the same cycle.
- R11: Writes to addresses 2, 3 and 4 take effect only while prot_i[0] is 1.
- R12: A write changes the register on the clock edge at which we_i is sampled; rdata_o follows addr_i combinationally, with unused bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| prot_i | input | 2 | Write enables from the protect register |
| pll_hi_freq_i | input | 1 | PLL output is 16 MHz or more |
| tmr_clk_f1_o | output | 1 | Timer clock is f1 (else f2) |
| sio_clk_f1_o | output | 1 | Serial clock is f1 (else f2) |
| sfr_wait1_o | output | 1 | SFR access uses one wait (else two) |
| clk_lock_o | output | 1 | Clock configuration lock |
| ring_osc_en_o | output | 1 | Ring oscillator enable |
| wdt_src_ring_o | output | 1 | Watchdog counts the ring oscillator |
| wdt_keep_run_o | output | 1 | Watchdog keeps running in wait and hold |
| bclk_keep_o | output | 1 | Bus clock keeps running on wait instruction |
| main_stop_o | output | 1 | Main clock stop |
| wait_clk_stop_o | output | 1 | Stop peripheral clocks in wait mode |
| cpu_src_o | output | 2 | CPU clock source select |
| stop_req_o | output | 1 | Stop-mode request |
| osc_det_en_o | output | 1 | Oscillation-stop detect enable |
| pll_ctrl_o | output | 8 | PLL control byte |
| pll_err_o | output | 1 | Sticky wait/PLL frequency error |

## Verification
The error flag is the hardest state to reach, because the wait bit cannot move while the PLL is enabled: the stimulus must first select one wait with the PLL off, then enable the PLL, then raise the high-frequency input, and only then try a clear while the condition still holds. The lock cases are nearly as awkward because the locks survive everything but reset, so the bench resets the block between the clock-lock and watchdog-lock scenarios and finishes with a long stretch of random writes checked every cycle against a behavioural model.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;
  localparam int unsigned CW = 3;
  localparam int unsigned PLL_EN_BIT = 7;

  typedef enum logic [AW-1:0] {
    A_PCLK = 3'd0,
    A_MODE = 3'd1,
    A_CLKA = 3'd2,
    A_CLKB = 3'd3,
    A_PLL  = 3'd4,
    A_STAT = 3'd5
  } reg_addr_e;

  localparam logic [1:0] PCLK_RST = 2'b11;
endpackage

// File: rtl/clk_cfg_mode_regs.sv
module clk_cfg_mode_regs
  import clk_cfg_pkg::*;
#(
  parameter int unsigned DW_P = DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_pclk_i,
  input  logic            wr_mode_i,
  input  logic [DW_P-1:0] wdata_i,
  input  logic            pll_en_i,
  output logic [1:0]      pclk_o,
  output logic            wait1_o,
  output logic            clk_lock_o,
  output logic            wdt_lock_o
);
  logic [1:0] pclk_q, pclk_d;
  logic       wait1_q, wait1_d;
  logic       clk_lock_q, clk_lock_d;
  logic       wdt_lock_q, wdt_lock_d;

  always_comb begin
    pclk_d     = pclk_q;
    wait1_d    = wait1_q;
    clk_lock_d = clk_lock_q;
    wdt_lock_d = wdt_lock_q;
    if (wr_pclk_i) pclk_d = wdata_i[1:0];
    if (wr_mode_i) begin
      if (!pll_en_i) wait1_d = wdata_i[0];
      // set-only: a zero write leaves the lock alone
      clk_lock_d = clk_lock_q | wdata_i[1];
      wdt_lock_d = wdt_lock_q | wdata_i[2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_q     <= PCLK_RST;
      wait1_q    <= 1'b0;
      clk_lock_q <= 1'b0;
      wdt_lock_q <= 1'b0;
    end else begin
      pclk_q     <= pclk_d;
      wait1_q    <= wait1_d;
      clk_lock_q <= clk_lock_d;
      wdt_lock_q <= wdt_lock_d;
    end
  end

  assign pclk_o     = pclk_q;
  assign wait1_o    = wait1_q;
  assign clk_lock_o = clk_lock_q;
  assign wdt_lock_o = wdt_lock_q;
endmodule

// File: rtl/clk_cfg_shadow.sv
module clk_cfg_shadow
  import clk_cfg_pkg::*;
#(
  parameter int unsigned DW_P = DW,
  parameter int unsigned CW_P = CW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_a_i,
  input  logic            wr_b_i,
  input  logic            wr_pll_i,
  input  logic [DW_P-1:0] wdata_i,
  input  logic            clk_lock_i,
  input  logic            wdt_lock_i,
  output logic [CW_P-1:0] a_o,
  output logic [CW_P-1:0] b_o,
  output logic [DW_P-1:0] pll_o
);
  logic [CW_P-1:0] a_q, b_q, a_blk, b_blk;
  logic [DW_P-1:0] pll_q;

  always_comb begin
    a_blk = {CW_P{clk_lock_i}};
    b_blk = {CW_P{clk_lock_i}};
    b_blk[0] = clk_lock_i | wdt_lock_i; // stop request also held by watchdog lock
  end

  for (genvar i = 0; i < CW_P; i++) begin : g_ctl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q[i] <= 1'b0;
        b_q[i] <= 1'b0;
      end else begin
        if (wr_a_i && !a_blk[i]) a_q[i] <= wdata_i[i];
        if (wr_b_i && !b_blk[i]) b_q[i] <= wdata_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pll_q <= '0;
    else if (wr_pll_i && !clk_lock_i) pll_q <= wdata_i;
  end

  assign a_o   = a_q;
  assign b_o   = b_q;
  assign pll_o = pll_q;
endmodule

// File: rtl/clk_cfg_err_mon.sv
module clk_cfg_err_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait1_i,
  input  logic pll_en_i,
  input  logic hi_freq_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q, set_w;

  assign set_w = wait1_i & pll_en_i & hi_freq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= set_w | (err_q & ~clr_i);
  end

  assign err_o = err_q;
endmodule

// File: rtl/clk_cfg_lock.sv
module clk_cfg_lock
  import clk_cfg_pkg::*;
#(
  parameter int unsigned AW_P = AW,
  parameter int unsigned DW_P = DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW_P-1:0] addr_i,
  input  logic            we_i,
  input  logic [DW_P-1:0] wdata_i,
  output logic [DW_P-1:0] rdata_o,
  input  logic [1:0]      prot_i,
  input  logic            pll_hi_freq_i,
  output logic            tmr_clk_f1_o,
  output logic            sio_clk_f1_o,
  output logic            sfr_wait1_o,
  output logic            clk_lock_o,
  output logic            ring_osc_en_o,
  output logic            wdt_src_ring_o,
  output logic            wdt_keep_run_o,
  output logic            bclk_keep_o,
  output logic            main_stop_o,
  output logic            wait_clk_stop_o,
  output logic [1:0]      cpu_src_o,
  output logic            stop_req_o,
  output logic            osc_det_en_o,
  output logic [DW_P-1:0] pll_ctrl_o,
  output logic            pll_err_o
);
  logic wr_pclk, wr_mode, wr_a, wr_b, wr_pll, clr_err;
  logic [1:0]      pclk;
  logic            wait1, clk_lock, wdt_lock, pll_en, err;
  logic [CW-1:0]   a_q, b_q;
  logic [DW_P-1:0] pll_q;

  always_comb begin
    wr_pclk = 1'b0;
    wr_mode = 1'b0;
    wr_a    = 1'b0;
    wr_b    = 1'b0;
    wr_pll  = 1'b0;
    clr_err = 1'b0;
    if (we_i) begin
      unique case (addr_i)
        A_PCLK:  wr_pclk = prot_i[0];
        A_MODE:  wr_mode = prot_i[1];
        A_CLKA:  wr_a    = prot_i[0];
        A_CLKB:  wr_b    = prot_i[0];
        A_PLL:   wr_pll  = prot_i[0];
        A_STAT:  clr_err = wdata_i[0];
        default: ;
      endcase
    end
  end

  assign pll_en = pll_q[PLL_EN_BIT];

  clk_cfg_mode_regs #(.DW_P(DW_P)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_pclk_i  (wr_pclk),
    .wr_mode_i  (wr_mode),
    .wdata_i    (wdata_i),
    .pll_en_i   (pll_en),
    .pclk_o     (pclk),
    .wait1_o    (wait1),
    .clk_lock_o (clk_lock),
    .wdt_lock_o (wdt_lock)
  );

  clk_cfg_shadow #(.DW_P(DW_P), .CW_P(CW)) u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_a_i     (wr_a),
    .wr_b_i     (wr_b),
    .wr_pll_i   (wr_pll),
    .wdata_i    (wdata_i),
    .clk_lock_i (clk_lock),
    .wdt_lock_i (wdt_lock),
    .a_o        (a_q),
    .b_o        (b_q),
    .pll_o      (pll_q)
  );

  clk_cfg_err_mon u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wait1_i   (wait1),
    .pll_en_i  (pll_en),
    .hi_freq_i (pll_hi_freq_i),
    .clr_i     (clr_err),
    .err_o     (err)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_PCLK:  rdata_o[1:0]    = pclk;
      A_MODE:  rdata_o[2:0]    = {wdt_lock, clk_lock, wait1};
      A_CLKA:  rdata_o[CW-1:0] = a_q;
      A_CLKB:  rdata_o[CW-1:0] = b_q;
      A_PLL:   rdata_o         = pll_q;
      A_STAT:  rdata_o[0]      = err;
      default: ;
    endcase
  end

  assign tmr_clk_f1_o    = pclk[0];
  assign sio_clk_f1_o    = pclk[1];
  assign sfr_wait1_o     = wait1;
  assign clk_lock_o      = clk_lock;
  assign bclk_keep_o     = clk_lock;
  assign ring_osc_en_o   = wdt_lock;
  assign wdt_src_ring_o  = wdt_lock;
  assign wdt_keep_run_o  = wdt_lock;
  assign main_stop_o     = a_q[0];
  assign wait_clk_stop_o = a_q[1];
  assign cpu_src_o       = {b_q[1], a_q[2]};
  assign stop_req_o      = b_q[0];
  assign osc_det_en_o    = b_q[2];
  assign pll_ctrl_o      = pll_q;
  assign pll_err_o       = err;
endmodule

// File: rtl/clk_cfg_lock_chk.sv
module clk_cfg_lock_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] addr_i,
  input logic       we_i,
  input logic [7:0] wdata_i,
  input logic [1:0] prot_i,
  input logic       tmr_clk_f1_o,
  input logic       sio_clk_f1_o,
  input logic       sfr_wait1_o,
  input logic       clk_lock_o,
  input logic       wdt_src_ring_o,
  input logic       main_stop_o,
  input logic [1:0] cpu_src_o,
  input logic       stop_req_o,
  input logic [7:0] pll_ctrl_o,
  input logic       pll_err_o
);
  p_pclk_guard_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 3'd0 && prot_i[0]) |=> $stable({sio_clk_f1_o, tmr_clk_f1_o}));

  p_wait_pll_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_ctrl_o[7] |=> $stable(sfr_wait1_o));

  p_clk_lock_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_lock_o |=> clk_lock_o);

  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_lock_o |=> ($stable(pll_ctrl_o) && $stable(main_stop_o) && $stable(cpu_src_o)));

  p_wdt_lock_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_src_ring_o |=> wdt_src_ring_o);

  p_stop_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_src_ring_o |=> $stable(stop_req_o));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_err_o && !(we_i && addr_i == 3'd5 && wdata_i[0])) |=> pll_err_o);
endmodule

bind clk_cfg_lock clk_cfg_lock_chk u_chk (.*);

// File: tb/tb_clk_cfg_lock.sv
`timescale 1ns/1ps
module tb_clk_cfg_lock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [1:0] prot = '0;
  logic       hi = 1'b0;
  logic [7:0] rdata;
  logic tmr, sio, w1, clk_lock, ring, wsrc, wkeep, bkeep, mstop, wstop, stopr, oscd, perr;
  logic [1:0] cpu;
  logic [7:0] pll;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  clk_cfg_lock dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .prot_i(prot), .pll_hi_freq_i(hi),
    .tmr_clk_f1_o(tmr), .sio_clk_f1_o(sio), .sfr_wait1_o(w1), .clk_lock_o(clk_lock),
    .ring_osc_en_o(ring), .wdt_src_ring_o(wsrc), .wdt_keep_run_o(wkeep),
    .bclk_keep_o(bkeep), .main_stop_o(mstop), .wait_clk_stop_o(wstop),
    .cpu_src_o(cpu), .stop_req_o(stopr), .osc_det_en_o(oscd),
    .pll_ctrl_o(pll), .pll_err_o(perr)
  );

  // behavioural reference state
  int m_pclk, m_wait, m_clk, m_wdt, m_a, m_b, m_pll, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pclk = 3; m_wait = 0; m_clk = 0; m_wdt = 0;
      m_a = 0; m_b = 0; m_pll = 0; m_err = 0;
    end else begin
      int o_wait, o_clk, o_wdt, o_pll7, wd, nb;
      o_wait = m_wait; o_clk = m_clk; o_wdt = m_wdt; o_pll7 = (m_pll >> 7) & 1;
      wd = wdata;
      if (we) begin
        if (addr == 0 && prot[0]) m_pclk = wd & 3;
        if (addr == 1 && prot[1]) begin
          if (o_pll7 == 0) m_wait = wd & 1;
          if (wd & 2) m_clk = 1;
          if (wd & 4) m_wdt = 1;
        end
        if (addr == 2 && prot[0] && !o_clk) m_a = wd & 7;
        if (addr == 3 && prot[0] && !o_clk) begin
          nb = wd & 6;
          nb = nb | ((o_wdt != 0) ? (m_b & 1) : (wd & 1));
          m_b = nb;
        end
        if (addr == 4 && prot[0] && !o_clk) m_pll = wd;
      end
      m_err = (o_wait && o_pll7 && hi) ? 1 :
              ((we && addr == 5 && wdata[0]) ? 0 : m_err);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_pclk;
      1: return m_wait | (m_clk << 1) | (m_wdt << 2);
      2: return m_a;
      3: return m_b;
      4: return m_pll;
      5: return m_err;
      default: return 0;
    endcase
  endfunction

  // per-cycle comparison, away from the edges
  always begin
    @(negedge clk);
    #2;
    chk("R2", "tmr_clk", tmr, m_pclk & 1);
    chk("R2", "sio_clk", sio, (m_pclk >> 1) & 1);
    chk("R4", "wait1", w1, m_wait);
    chk("R5", "clk_lock", clk_lock, m_clk);
    chk("R6", "bclk_keep", bkeep, m_clk);
    chk("R7", "ring/src/keep", {ring, wsrc, wkeep}, m_wdt ? 7 : 0);
    chk("R6", "clka", {cpu[0], wstop, mstop}, m_a);
    chk("R8", "clkb", {oscd, cpu[1], stopr}, m_b);
    chk("R6", "pll", pll, m_pll);
    chk("R10", "err", perr, m_err);
    chk("R12", "rdata", rdata, exp_rd(addr));
  end

  task automatic wr(input int a, input int d, input int p);
    @(negedge clk);
    addr = a[2:0]; wdata = d[7:0]; prot = p[1:0]; we = 1'b1;
    @(negedge clk);
    we = 1'b0; prot = 2'b00;
  endtask

  task automatic rd(input int a, input string req, input int exp);
    @(negedge clk);
    addr = a[2:0];
    #3;
    chk(req, "read", rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset values
    rd(0, "R1", 8'h03); rd(1, "R1", 0); rd(2, "R1", 0);
    rd(3, "R1", 0); rd(4, "R1", 0); rd(5, "R1", 0);
    // R2: unprotected write ignored, reserved bits read 0
    wr(0, 8'hFC, 2'b10); rd(0, "R2", 8'h03);
    wr(0, 8'hFD, 2'b01); rd(0, "R2", 8'h01);
    // R3: mode needs prot bit1, upper bits discarded
    wr(1, 8'hE1, 2'b01); rd(1, "R3", 0);
    wr(1, 8'hE1, 2'b10); rd(1, "R3", 8'h01);
    // R11: shadow registers need prot bit0
    wr(2, 8'h07, 2'b10); rd(2, "R11", 0);
    wr(2, 8'h05, 2'b01); rd(2, "R11", 8'h05);
    wr(3, 8'h07, 2'b01); rd(3, "R11", 8'h07);
    // R4: wait bit with PLL on then off
    wr(4, 8'h80, 2'b01);
    wr(1, 8'h00, 2'b10); rd(1, "R4", 8'h01);
    wr(4, 8'h00, 2'b01);
    wr(1, 8'h00, 2'b10); rd(1, "R4", 0);
    // R10: error flag
    wr(1, 8'h01, 2'b10); wr(4, 8'h81, 2'b01);
    @(negedge clk); hi = 1'b1;
    @(negedge clk); rd(5, "R10", 1);
    wr(5, 8'h01, 2'b00); rd(5, "R10", 1);
    @(negedge clk); hi = 1'b0;
    @(negedge clk); rd(5, "R10", 1);
    wr(5, 8'h00, 2'b00); rd(5, "R10", 1);
    wr(5, 8'h01, 2'b00); rd(5, "R10", 0);
    wr(4, 8'h00, 2'b01);
    // R9 + R5: set lock and clear wait in one write, then try to clear lock
    wr(1, 8'h02, 2'b10); rd(1, "R9", 8'h02);
    wr(1, 8'h01, 2'b10); rd(1, "R5", 8'h03);
    // R6: blocked writes under clock lock
    wr(2, 8'h02, 2'b01); rd(2, "R6", 8'h05);
    wr(3, 8'h00, 2'b01); rd(3, "R6", 8'h07);
    wr(4, 8'h33, 2'b01); rd(4, "R6", 0);
    wr(0, 8'h02, 2'b01); rd(0, "R6", 8'h02);
    // R7/R8: watchdog lock after reset
    do_reset();
    wr(3, 8'h01, 2'b01);
    wr(1, 8'h04, 2'b10); rd(1, "R7", 8'h04);
    wr(1, 8'h00, 2'b10); rd(1, "R7", 8'h04);
    wr(3, 8'h04, 2'b01); rd(3, "R8", 8'h05);
    wr(3, 8'h02, 2'b01); rd(3, "R8", 8'h03);
    // random traffic, compared every cycle
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      addr  = 3'($urandom_range(0, 6));
      wdata = 8'($urandom);
      prot  = 2'($urandom);
      we    = ($urandom_range(0, 3) != 0);
      if ((i % 50) == 0) hi = ~hi;
      if (addr == 3'd1 && ($urandom_range(0, 7) != 0)) wdata[2:1] = 2'b00;
      if (i == 1500) begin we = 1'b0; rst_n = 1'b0; end
      else rst_n = 1'b1;
    end
    @(negedge clk); we = 1'b0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule